// File: doc/BRIEF.md
# Spare Lane Steering Logic

This block repairs one broken wire on a wide parallel chip-to-chip link. Each link is divided into repair groups of data lanes, and each group carries one extra spare wire above its top lane. Every lane has its own repair bit on each chip. On the sending chip, a lane whose bit is set drives the data of the logical bit just below it. This pushes all traffic at and above the broken position one wire upward, and the top bit ends up on the spare wire. On the receiving chip, the same repair bits make each marked lane take the wire just above it, which puts the bits back in their logical order.

The repair pattern is a thermometer: every lane from the broken index up to the top lane is marked. Any other pattern is reported as a configuration error. Each group also reports when its send and receive patterns differ. A loopback self-check runs the steered send data back through the receive un-steering and compares the result with the host data. The steered wires and the restored host data are both registered, so each has one cycle of latency.

Top module: `spare_steer`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: With a group's send pattern all zero, its wires 0..LANES-1 carry that group's host bits unchanged one cycle later.
- R3: While the top lane bit of a group's send pattern is clear, the group's spare wire (index LANES within the group) drives the idle level SPARE_LEVEL (default 1).
- R4: With the send pattern marking lanes k..LANES-1, wires below k carry their own host bit, wire j for k < j <= LANES carries host bit j-1, and wire k carries host bit k-1 (0 when k = 0), one cycle later.
- R5: Restored host bit i equals wire i+1 when receive bit i is set and wire i otherwise, one cycle after the wires arrive.
- R6: `cfg_err[g]` is 1 one cycle after the send or receive pattern of group g is not of the form "all lanes from some index upward set" (the all-zero pattern is valid).
- R7: `cfg_mismatch[g]` is 1 one cycle after group g's send and receive patterns differ.
- R8: `loop_err[g]` is 1 one cycle after un-steering group g's steered send data with its receive pattern fails to reproduce that group's host data.
- R9: Groups are independent: the pattern and data of one group never affect another group's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_data | input | GROUPS*LANES | Logical data to send |
| tx_cfg | input | GROUPS*LANES | Per-lane repair bits, sending side |
| rx_cfg | input | GROUPS*LANES | Per-lane repair bits, receiving side |
| wire_in | input | GROUPS*(LANES+1) | Physical wires arriving from the far chip |
| wire_out | output | GROUPS*(LANES+1) | Steered physical wires sent to the far chip |
| host_out | output | GROUPS*LANES | Restored logical data |
| cfg_err | output | GROUPS | Non-thermometer pattern seen, per group |
| cfg_mismatch | output | GROUPS | Send and receive patterns differ, per group |
| loop_err | output | GROUPS | Loopback self-check failed, per group |

## Verification
The checker checks a set of properties on every cycle. Without repair, the wires pass the host data straight through and the spare holds its idle level. When the top lane is marked, the spare carries the top host bit. Matching valid patterns never raise the mismatch or loopback flags, and the all-zero pattern never raises a configuration error. The exact placement of every bit for each repair index, the unshifting on the receive side, and which invalid or mismatched patterns raise which flag can only be shown by the bench. It sweeps every pair of send and receive repair indices over random data, then adds random broken patterns, while the second group runs a different repair to show that the groups stay independent.

// File: rtl/spare_steer_pkg.sv
package spare_steer_pkg;
   // A valid repair pattern: once a lane is marked, every higher lane is too.
   function automatic logic thermo_ok(input logic [63:0] cfg, input int unsigned n);
      logic ok;
      ok = 1'b1;
      for (int unsigned i = 0; i + 1 < n; i++) begin
         if (cfg[i] && !cfg[i+1]) ok = 1'b0;
      end
      return ok;
   endfunction
endpackage

// File: rtl/spare_tx_steer.sv
module spare_tx_steer #(
   parameter int unsigned LANES = 16
) (
   input  logic [LANES-1:0] data_i,
   input  logic [LANES-1:0] cfg_i,
   input  logic             fill_i,
   output logic [LANES:0]   wires_o
);
   // Lane 0 has no lower neighbour; a marked lane 0 drives 0 on its broken wire.
   assign wires_o[0] = cfg_i[0] ? 1'b0 : data_i[0];

   for (genvar i = 1; i < LANES; i++) begin : g_lane
      assign wires_o[i] = cfg_i[i] ? data_i[i-1] : data_i[i];
   end

   // Spare wire: top logical bit when the top lane is shifted, idle fill otherwise.
   assign wires_o[LANES] = cfg_i[LANES-1] ? data_i[LANES-1] : fill_i;
endmodule

// File: rtl/spare_rx_unsteer.sv
module spare_rx_unsteer #(
   parameter int unsigned LANES = 16
) (
   input  logic [LANES:0]   wires_i,
   input  logic [LANES-1:0] cfg_i,
   output logic [LANES-1:0] data_o
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign data_o[i] = cfg_i[i] ? wires_i[i+1] : wires_i[i];
   end
endmodule

// File: rtl/spare_cfg_check.sv
module spare_cfg_check
   import spare_steer_pkg::*;
#(
   parameter int unsigned LANES = 16
) (
   input  logic [LANES-1:0] tx_cfg_i,
   input  logic [LANES-1:0] rx_cfg_i,
   output logic             bad_o,
   output logic             diff_o
);
   logic [63:0] tx_w, rx_w;
   always_comb begin
      tx_w = '0;
      rx_w = '0;
      tx_w[LANES-1:0] = tx_cfg_i;
      rx_w[LANES-1:0] = rx_cfg_i;
      bad_o  = !(thermo_ok(tx_w, LANES) && thermo_ok(rx_w, LANES));
      diff_o = (tx_cfg_i != rx_cfg_i);
   end
endmodule

// File: rtl/spare_steer.sv
module spare_steer #(
   parameter int unsigned GROUPS      = 2,
   parameter int unsigned LANES       = 16,
   parameter bit          IDLE_TOGGLE = 1'b0,
   parameter bit          SPARE_LEVEL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [GROUPS*LANES-1:0]       host_data,
   input  logic [GROUPS*LANES-1:0]       tx_cfg,
   input  logic [GROUPS*LANES-1:0]       rx_cfg,
   input  logic [GROUPS*(LANES+1)-1:0]   wire_in,
   output logic [GROUPS*(LANES+1)-1:0]   wire_out,
   output logic [GROUPS*LANES-1:0]       host_out,
   output logic [GROUPS-1:0]             cfg_err,
   output logic [GROUPS-1:0]             cfg_mismatch,
   output logic [GROUPS-1:0]             loop_err
);
   localparam int unsigned WW = LANES + 1;

   if (LANES < 2 || LANES > 64) begin : g_bad_lanes
      $error("spare_steer: LANES must be within 2..64");
   end
   if (GROUPS < 1) begin : g_bad_groups
      $error("spare_steer: GROUPS must be at least 1");
   end

   // Idle fill for unused spare wires: fixed level or a toggling pattern.
   logic fill;
   if (IDLE_TOGGLE) begin : g_fill_tog
      logic tog_q;
      always_ff @(posedge clk) begin
         if (!rst_n) tog_q <= SPARE_LEVEL;
         else        tog_q <= ~tog_q;
      end
      assign fill = tog_q;
   end else begin : g_fill_fix
      assign fill = SPARE_LEVEL;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [WW-1:0]    tx_w;
      logic [LANES-1:0] rx_d;
      logic [LANES-1:0] lb_d;
      logic             bad, diff;

      spare_tx_steer #(.LANES(LANES)) u_tx (
         .data_i (host_data[g*LANES +: LANES]),
         .cfg_i  (tx_cfg[g*LANES +: LANES]),
         .fill_i (fill),
         .wires_o(tx_w)
      );

      spare_rx_unsteer #(.LANES(LANES)) u_rx (
         .wires_i(wire_in[g*WW +: WW]),
         .cfg_i  (rx_cfg[g*LANES +: LANES]),
         .data_o (rx_d)
      );

      // Loopback: own steered wires through own receive pattern.
      spare_rx_unsteer #(.LANES(LANES)) u_lb (
         .wires_i(tx_w),
         .cfg_i  (rx_cfg[g*LANES +: LANES]),
         .data_o (lb_d)
      );

      spare_cfg_check #(.LANES(LANES)) u_chk (
         .tx_cfg_i(tx_cfg[g*LANES +: LANES]),
         .rx_cfg_i(rx_cfg[g*LANES +: LANES]),
         .bad_o   (bad),
         .diff_o  (diff)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wire_out[g*WW +: WW]       <= '0;
            host_out[g*LANES +: LANES] <= '0;
            cfg_err[g]                 <= 1'b0;
            cfg_mismatch[g]            <= 1'b0;
            loop_err[g]                <= 1'b0;
         end else begin
            wire_out[g*WW +: WW]       <= tx_w;
            host_out[g*LANES +: LANES] <= rx_d;
            cfg_err[g]                 <= bad;
            cfg_mismatch[g]            <= diff;
            loop_err[g]                <= (lb_d != host_data[g*LANES +: LANES]);
         end
      end
   end
endmodule

// File: rtl/spare_steer_chk.sv
module spare_steer_chk #(
   parameter int unsigned GROUPS      = 2,
   parameter int unsigned LANES       = 16,
   parameter bit          IDLE_TOGGLE = 1'b0,
   parameter bit          SPARE_LEVEL = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [GROUPS*LANES-1:0]     host_data,
   input logic [GROUPS*LANES-1:0]     tx_cfg,
   input logic [GROUPS*LANES-1:0]     rx_cfg,
   input logic [GROUPS*(LANES+1)-1:0] wire_in,
   input logic [GROUPS*(LANES+1)-1:0] wire_out,
   input logic [GROUPS*LANES-1:0]     host_out,
   input logic [GROUPS-1:0]           cfg_err,
   input logic [GROUPS-1:0]           cfg_mismatch,
   input logic [GROUPS-1:0]           loop_err
);
   localparam int unsigned WW = LANES + 1;

   // Armed one cycle after reset release so $past never reaches into reset.
   logic armed;
   always_ff @(posedge clk) armed <= rst_n;

   // R1
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $past(!rst_n) && !rst_n |-> (wire_out == '0 && host_out == '0 && cfg_err == '0));

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(tx_cfg[g*LANES +: LANES]) == '0
         |-> wire_out[g*WW +: LANES] == $past(host_data[g*LANES +: LANES]));

      if (!IDLE_TOGGLE) begin : g_idle
         assert_spare_idle_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            !$past(tx_cfg[g*LANES + LANES-1]) |-> wire_out[g*WW + LANES] == SPARE_LEVEL);
      end

      assert_spare_top_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(tx_cfg[g*LANES + LANES-1])
         |-> wire_out[g*WW + LANES] == $past(host_data[g*LANES + LANES-1]));

      assert_rx_pass_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(rx_cfg[g*LANES +: LANES]) == '0
         |-> host_out[g*LANES +: LANES] == $past(wire_in[g*WW +: LANES]));

      assert_zero_valid_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(tx_cfg[g*LANES +: LANES]) == '0 && $past(rx_cfg[g*LANES +: LANES]) == '0)
         |-> !cfg_err[g]);

      assert_match_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(tx_cfg[g*LANES +: LANES]) == $past(rx_cfg[g*LANES +: LANES])
         |-> !cfg_mismatch[g]);

      assert_loop_clean_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(tx_cfg[g*LANES +: LANES]) == $past(rx_cfg[g*LANES +: LANES]) && !cfg_err[g])
         |-> !loop_err[g]);
   end
endmodule

bind spare_steer spare_steer_chk #(
   .GROUPS(GROUPS), .LANES(LANES), .IDLE_TOGGLE(IDLE_TOGGLE), .SPARE_LEVEL(SPARE_LEVEL)
) chk_i (.*);

// File: tb/spare_steer_tb_top.sv
`timescale 1ns/1ps
module spare_steer_tb_top;
   localparam int L  = 16;
   localparam int G  = 2;
   localparam int WW = L + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [G*L-1:0]  host_data = '0, tx_cfg = '0, rx_cfg = '0, host_out;
   logic [G*WW-1:0] wire_in = '0, wire_out;
   logic [G-1:0]    cfg_err, cfg_mismatch, loop_err;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   spare_steer dut_i (
      .clk(clk), .rst_n(rst_n), .host_data(host_data), .tx_cfg(tx_cfg),
      .rx_cfg(rx_cfg), .wire_in(wire_in), .wire_out(wire_out), .host_out(host_out),
      .cfg_err(cfg_err), .cfg_mismatch(cfg_mismatch), .loop_err(loop_err)
   );

   function automatic logic [L-1:0] therm(input int k);
      return (k >= L) ? '0 : ({L{1'b1}} << k);
   endfunction

   // Model from R3/R4.
   function automatic logic [WW-1:0] m_steer(input logic [L-1:0] d, input logic [L-1:0] c);
      logic [WW-1:0] w;
      for (int i = 0; i < L; i++)
         w[i] = c[i] ? ((i == 0) ? 1'b0 : d[i-1]) : d[i];
      w[L] = c[L-1] ? d[L-1] : 1'b1;
      return w;
   endfunction

   // Model from R5.
   function automatic logic [L-1:0] m_unsteer(input logic [WW-1:0] w, input logic [L-1:0] c);
      logic [L-1:0] d;
      for (int i = 0; i < L; i++) d[i] = c[i] ? w[i+1] : w[i];
      return d;
   endfunction

   function automatic logic m_bad(input logic [L-1:0] c);
      logic b = 1'b0;
      for (int i = 0; i + 1 < L; i++) if (c[i] && !c[i+1]) b = 1'b1;
      return b;
   endfunction

   task automatic report(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
   endtask

   // Checks one group's outputs; sampled at the negedge after the capturing posedge.
   task automatic check_group(input int g);
      logic [L-1:0]  d, tc, rc, eh;
      logic [WW-1:0] wi, ew;
      d  = host_data[g*L +: L];
      tc = tx_cfg[g*L +: L];
      rc = rx_cfg[g*L +: L];
      wi = wire_in[g*WW +: WW];
      ew = m_steer(d, tc);
      eh = m_unsteer(wi, rc);
      if (wire_out[g*WW +: WW] !== ew)
         report((tc == '0) ? "R2 R3 R9" : "R4 R9", "wire_out", 64'(wire_out[g*WW +: WW]), 64'(ew));
      if (host_out[g*L +: L] !== eh)
         report("R5 R9", "host_out", 64'(host_out[g*L +: L]), 64'(eh));
      if (cfg_err[g] !== (m_bad(tc) || m_bad(rc)))
         report("R6", "cfg_err", 64'(cfg_err[g]), 64'(m_bad(tc) || m_bad(rc)));
      if (cfg_mismatch[g] !== (tc != rc))
         report("R7", "cfg_mismatch", 64'(cfg_mismatch[g]), 64'(tc != rc));
      if (loop_err[g] !== (m_unsteer(ew, rc) != d))
         report("R8", "loop_err", 64'(loop_err[g]), 64'(m_unsteer(ew, rc) != d));
   endtask

   task automatic apply(input logic [G*L-1:0] d, input logic [G*L-1:0] tc,
                        input logic [G*L-1:0] rc, input logic [G*WW-1:0] wi);
      @(negedge clk);
      host_data = d; tx_cfg = tc; rx_cfg = rc; wire_in = wi;
      @(negedge clk);
      vectors++;
      for (int g = 0; g < G; g++) check_group(g);
   endtask

   function automatic logic [G*WW-1:0] rnd_wires();
      return {$urandom, $urandom};
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      host_data = '1; tx_cfg = '1; rx_cfg = '0; wire_in = '1;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero in reset despite busy inputs.
      vectors++;
      if (wire_out !== '0 || host_out !== '0 || cfg_err !== '0 || cfg_mismatch !== '0 || loop_err !== '0)
         report("R1", "reset outputs", 64'(wire_out), 64'(0));
      rst_n = 1'b1;

      // R2 R3: all-ones and all-zero data without repair.
      apply('0, '0, '0, '0);
      apply('1, '0, '0, '1);
      apply({G{16'hA5C3}}, '0, '0, rnd_wires());

      // Sweep every send/receive repair index pair; group 1 uses a shifted index (R9).
      for (int tk = 0; tk <= L; tk++) begin
         for (int rk = 0; rk <= L; rk++) begin
            int tk1 = (tk + 5) % (L + 1);
            int rk1 = (rk + 11) % (L + 1);
            apply({$urandom}, {therm(tk1), therm(tk)}, {therm(rk1), therm(rk)}, rnd_wires());
         end
      end

      // R6: random, mostly non-thermometer patterns on either side.
      for (int n = 0; n < 200; n++) begin
         logic [G*L-1:0] tc = {$urandom};
         logic [G*L-1:0] rc = (n % 2) ? tc : {$urandom};
         apply({$urandom}, tc, rc, rnd_wires());
      end

      // R4 corner: repair at lane 0 with alternating data.
      apply({G{16'h5555}}, {G{therm(0)}}, {G{therm(0)}}, rnd_wires());
      apply({G{16'hAAAA}}, {G{therm(L-1)}}, {G{therm(L-1)}}, rnd_wires());

      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         finish_run();
      end
   end
endmodule